// File: doc/BRIEF.md
# Micro-op effect signature generator

This block sits next to the instruction decoder of an error-checking core. For every decoded micro-op it forms a record of what the micro-op should change in architectural state. The record holds the operation class, the address-generation operation, both source register numbers, the immediate, the destination register number and the expected next PC. It compresses the record into two independent 5-bit CRC signatures. The PC signature covers the expected next PC. The register/memory signature covers everything else. Together they form a 10-bit expectation.

A second port takes what a micro-op actually did and hashes it with the same packing and CRC logic. Commit-time logic can then compare the two sides bit for bit. For the observed side, the PC signature is taken over the micro-op's own PC. It is compared later against the previous micro-op's expected next PC.

A third port serves branch resolution. When the resolved target disagrees with the predicted next PC, it produces a replacement PC signature over the resolved target and flags that a rewrite is needed.

Top module: `effect_sig_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first capture, all outputs are zero. The outputs are `exp_valid`, `obs_sig_valid` and `fix_valid`, and every signature bit.
- R2: Signatures use CRC-5 with polynomial x^5+x^2+1 (feedback mask 5'b00101) and an all-zero start value. Each is computed over its input MSB first. The register/memory record is packed from MSB to LSB as follows:
  - op class (4 bits)
  - address op (4 bits)
  - src1 valid flag (1 bit) and src1 number (6 bits)
  - src2 valid flag (1 bit) and src2 number (6 bits)
  - immediate (32 bits)
  - destination valid flag (1 bit) and destination number (6 bits)

  This gives 61 bits in total.
- R3: For a decoded micro-op whose class is not a control transfer, the expected PC signature is the CRC of `dec_pc + 4` taken modulo 2^32.
- R4: For the control-transfer classes BRANCH (8) and JUMP (9), the expected PC signature is the CRC of `dec_pred_npc`.
- R5: For the memory classes LOAD (6) and STORE (7), the expected address op field is ADD (1). For every other class it is 0.
- R6: A register field whose valid flag is 0 is hashed as zeros, so its register number has no effect on the signature.
- R7: The observed port packs its fields the same way and hashes them with the same CRC. Its address op comes from `obs_agu_op`. Its PC signature is the CRC of `obs_pc`.
- R8: On `br_valid`, `fix_valid` is 1 exactly when `br_target` differs from `br_pred_npc`. `fix_pc_sig` is the CRC of `br_target`.
- R9: With `REG_OUT=1`, every output shows its inputs one clock later. Each output valid equals its input valid from the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | Decoded micro-op present |
| dec_op | input | 4 | Operation class of the decoded micro-op |
| dec_pc | input | 32 | PC of the decoded micro-op |
| dec_pred_npc | input | 32 | Predicted next PC |
| dec_src1_vld | input | 1 | Source 1 present |
| dec_src1 | input | 6 | Source 1 architectural register |
| dec_src2_vld | input | 1 | Source 2 present |
| dec_src2 | input | 6 | Source 2 architectural register |
| dec_imm | input | 32 | Immediate |
| dec_dst_vld | input | 1 | Destination present |
| dec_dst | input | 6 | Destination architectural register |
| exp_valid | output | 1 | Expectation signatures valid |
| exp_pc_sig | output | 5 | Expected next-PC signature |
| exp_rm_sig | output | 5 | Expected register/memory signature |
| obs_valid | input | 1 | Observed micro-op effects present |
| obs_op | input | 4 | Operation class actually performed |
| obs_agu_op | input | 4 | Address operation actually performed |
| obs_pc | input | 32 | PC of the observed micro-op |
| obs_src1_vld | input | 1 | Source 1 actually read |
| obs_src1 | input | 6 | Source 1 register actually read |
| obs_src2_vld | input | 1 | Source 2 actually read |
| obs_src2 | input | 6 | Source 2 register actually read |
| obs_imm | input | 32 | Immediate actually used |
| obs_dst_vld | input | 1 | Destination actually written |
| obs_dst | input | 6 | Destination register actually written |
| obs_sig_valid | output | 1 | History signatures valid |
| obs_pc_sig | output | 5 | Signature of the micro-op's own PC |
| obs_rm_sig | output | 5 | Observed register/memory signature |
| br_valid | input | 1 | Branch resolution present |
| br_pred_npc | input | 32 | Next PC predicted for the branch |
| br_target | input | 32 | Resolved next PC |
| fix_valid | output | 1 | PC signature must be replaced |
| fix_pc_sig | output | 5 | Replacement PC signature |

## Verification
The hardest situation to reach is the exact agreement between the expectation and observed ports. For that, the two independent input sets must describe the same micro-op in the same cycle. Random stimulus almost never lines them up, so the bench drives the observed port from the decoded fields in most iterations. It sets the observed address op the way a memory op would report it, and it points the observed PC at the decoded PC plus 4. The remaining iterations deliberately perturb one field. Directed cases cover:
- the PC wrapping past 2^32;
- masked operands carrying different register numbers;
- branch resolutions that agree and disagree with the prediction.

// File: rtl/sig_pkg.sv
// Shared definitions for the effect signature generator.
// Assumes 4-bit operation classes; encodings are fixed because the
// commit-side comparator decodes the same values.
package sig_pkg;
    localparam int OP_W  = 4;
    localparam int SIG_W = 5;

    typedef enum logic [OP_W-1:0] {
        OPC_NOP    = 4'd0,
        OPC_ADD    = 4'd1,
        OPC_SUB    = 4'd2,
        OPC_LOGIC  = 4'd3,
        OPC_SHIFT  = 4'd4,
        OPC_MUL    = 4'd5,
        OPC_LOAD   = 4'd6,
        OPC_STORE  = 4'd7,
        OPC_BRANCH = 4'd8,
        OPC_JUMP   = 4'd9
    } op_class_e;

    // True for classes whose next PC is not sequential
    function automatic logic is_ctrl(input logic [OP_W-1:0] op);
        return (op == OPC_BRANCH) || (op == OPC_JUMP);
    endfunction

    // True for classes that compute an address and access memory
    function automatic logic is_mem(input logic [OP_W-1:0] op);
        return (op == OPC_LOAD) || (op == OPC_STORE);
    endfunction
endpackage

// File: rtl/sig_crc5.sv
// Combinational CRC-5 over a W-bit vector, MSB first, zero start value.
// Assumes POLY holds the feedback taps without the x^5 term.
module sig_crc5 #(
    parameter int          W    = 32,
    parameter logic [4:0]  POLY = 5'b00101
) (
    input  logic [W-1:0] data,
    output logic [4:0]   sig
);
    // Unrolled serial shift: one feedback step per data bit
    always_comb begin
        logic [4:0] acc;
        logic       fb;
        acc = '0;
        for (int i = W - 1; i >= 0; i--) begin
            fb  = acc[4] ^ data[i];
            acc = {acc[3:0], 1'b0} ^ (fb ? POLY : 5'b00000);
        end
        sig = acc;
    end
endmodule

// File: rtl/sig_rm_pack.sv
// Packs register/memory effects into the fixed record order used by
// both sides. Absent register fields are forced to zero so their
// numbers never reach the hash.
module sig_rm_pack #(
    parameter int OP_W   = 4,
    parameter int AREG_W = 6,
    parameter int XLEN   = 32,
    localparam int RM_W  = 2*OP_W + 3*(1+AREG_W) + XLEN
) (
    input  logic [OP_W-1:0]   op,
    input  logic [OP_W-1:0]   agu_op,
    input  logic              s1_vld,
    input  logic [AREG_W-1:0] s1,
    input  logic              s2_vld,
    input  logic [AREG_W-1:0] s2,
    input  logic [XLEN-1:0]   imm,
    input  logic              d_vld,
    input  logic [AREG_W-1:0] d,
    output logic [RM_W-1:0]   rec
);
    // Mask absent operands and concatenate in the hashed order
    always_comb begin
        rec = {op, agu_op,
               s1_vld, (s1_vld ? s1 : {AREG_W{1'b0}}),
               s2_vld, (s2_vld ? s2 : {AREG_W{1'b0}}),
               imm,
               d_vld,  (d_vld  ? d  : {AREG_W{1'b0}})};
    end
endmodule

// File: rtl/sig_stage.sv
// Optional output stage: a reset register when EN is set, a wire otherwise.
module sig_stage #(
    parameter int W  = 11,
    parameter bit EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    if (EN) begin : g_reg
        // Capture every cycle, clear on synchronous reset
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= d;
        end
    end else begin : g_wire
        assign q = d;
    end
endmodule

// File: rtl/effect_sig_gen.sv
// Builds split PC and register/memory signatures for decoded micro-ops,
// for observed micro-op effects, and for resolved branch targets.
// Assumes fixed 4-byte instructions and registered outputs by default.
module effect_sig_gen
    import sig_pkg::*;
#(
    parameter int         XLEN       = 32,
    parameter int         AREG_W     = 6,
    parameter int         INSN_BYTES = 4,
    parameter bit         REG_OUT    = 1'b1,
    parameter logic [4:0] CRC_POLY   = 5'b00101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_valid,
    input  logic [OP_W-1:0]   dec_op,
    input  logic [XLEN-1:0]   dec_pc,
    input  logic [XLEN-1:0]   dec_pred_npc,
    input  logic              dec_src1_vld,
    input  logic [AREG_W-1:0] dec_src1,
    input  logic              dec_src2_vld,
    input  logic [AREG_W-1:0] dec_src2,
    input  logic [XLEN-1:0]   dec_imm,
    input  logic              dec_dst_vld,
    input  logic [AREG_W-1:0] dec_dst,
    output logic              exp_valid,
    output logic [SIG_W-1:0]  exp_pc_sig,
    output logic [SIG_W-1:0]  exp_rm_sig,
    input  logic              obs_valid,
    input  logic [OP_W-1:0]   obs_op,
    input  logic [OP_W-1:0]   obs_agu_op,
    input  logic [XLEN-1:0]   obs_pc,
    input  logic              obs_src1_vld,
    input  logic [AREG_W-1:0] obs_src1,
    input  logic              obs_src2_vld,
    input  logic [AREG_W-1:0] obs_src2,
    input  logic [XLEN-1:0]   obs_imm,
    input  logic              obs_dst_vld,
    input  logic [AREG_W-1:0] obs_dst,
    output logic              obs_sig_valid,
    output logic [SIG_W-1:0]  obs_pc_sig,
    output logic [SIG_W-1:0]  obs_rm_sig,
    input  logic              br_valid,
    input  logic [XLEN-1:0]   br_pred_npc,
    input  logic [XLEN-1:0]   br_target,
    output logic              fix_valid,
    output logic [SIG_W-1:0]  fix_pc_sig
);
    localparam int RM_W  = 2*OP_W + 3*(1+AREG_W) + XLEN;
    localparam int SIDE_W = 1 + 2*SIG_W;
    localparam int FIX_W  = 1 + SIG_W;

    logic [XLEN-1:0]  exp_npc;
    logic [OP_W-1:0]  exp_agu;
    logic [RM_W-1:0]  exp_rec, obs_rec;
    logic [SIG_W-1:0] exp_pc_c, exp_rm_c, obs_pc_c, obs_rm_c, fix_pc_c;
    logic             fix_need;

    // Expected next PC: prediction for control transfers, else sequential
    always_comb begin
        if (is_ctrl(dec_op)) exp_npc = dec_pred_npc;
        else                 exp_npc = dec_pc + XLEN'(INSN_BYTES);
    end

    // Memory ops also expect an address add in the ALU
    always_comb begin
        exp_agu = is_mem(dec_op) ? OPC_ADD : OPC_NOP;
    end

    // Rewrite is needed only when resolution disagrees with prediction
    always_comb begin
        fix_need = br_valid && (br_target != br_pred_npc);
    end

    sig_rm_pack #(.OP_W(OP_W), .AREG_W(AREG_W), .XLEN(XLEN)) u_exp_pack (
        .op(dec_op), .agu_op(exp_agu),
        .s1_vld(dec_src1_vld), .s1(dec_src1),
        .s2_vld(dec_src2_vld), .s2(dec_src2),
        .imm(dec_imm), .d_vld(dec_dst_vld), .d(dec_dst),
        .rec(exp_rec)
    );

    sig_rm_pack #(.OP_W(OP_W), .AREG_W(AREG_W), .XLEN(XLEN)) u_obs_pack (
        .op(obs_op), .agu_op(obs_agu_op),
        .s1_vld(obs_src1_vld), .s1(obs_src1),
        .s2_vld(obs_src2_vld), .s2(obs_src2),
        .imm(obs_imm), .d_vld(obs_dst_vld), .d(obs_dst),
        .rec(obs_rec)
    );

    sig_crc5 #(.W(XLEN), .POLY(CRC_POLY)) u_crc_exp_pc (.data(exp_npc),  .sig(exp_pc_c));
    sig_crc5 #(.W(RM_W), .POLY(CRC_POLY)) u_crc_exp_rm (.data(exp_rec),  .sig(exp_rm_c));
    sig_crc5 #(.W(XLEN), .POLY(CRC_POLY)) u_crc_obs_pc (.data(obs_pc),   .sig(obs_pc_c));
    sig_crc5 #(.W(RM_W), .POLY(CRC_POLY)) u_crc_obs_rm (.data(obs_rec),  .sig(obs_rm_c));
    sig_crc5 #(.W(XLEN), .POLY(CRC_POLY)) u_crc_fix    (.data(br_target), .sig(fix_pc_c));

    sig_stage #(.W(SIDE_W), .EN(REG_OUT)) u_exp_stage (
        .clk(clk), .rst_n(rst_n),
        .d({dec_valid, exp_pc_c, exp_rm_c}),
        .q({exp_valid, exp_pc_sig, exp_rm_sig})
    );

    sig_stage #(.W(SIDE_W), .EN(REG_OUT)) u_obs_stage (
        .clk(clk), .rst_n(rst_n),
        .d({obs_valid, obs_pc_c, obs_rm_c}),
        .q({obs_sig_valid, obs_pc_sig, obs_rm_sig})
    );

    sig_stage #(.W(FIX_W), .EN(REG_OUT)) u_fix_stage (
        .clk(clk), .rst_n(rst_n),
        .d({fix_need, fix_pc_c}),
        .q({fix_valid, fix_pc_sig})
    );
endmodule

// File: rtl/effect_sig_gen_chk.sv
// Temporal checks for effect_sig_gen with registered outputs.
// Relates input events to output behaviour one cycle later.
module effect_sig_gen_chk
    import sig_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int AREG_W  = 6,
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dec_valid,
    input logic [OP_W-1:0]   dec_op,
    input logic [XLEN-1:0]   dec_pc,
    input logic              dec_src1_vld,
    input logic [AREG_W-1:0] dec_src1,
    input logic              dec_src2_vld,
    input logic [AREG_W-1:0] dec_src2,
    input logic [XLEN-1:0]   dec_imm,
    input logic              dec_dst_vld,
    input logic [AREG_W-1:0] dec_dst,
    input logic              exp_valid,
    input logic [SIG_W-1:0]  exp_pc_sig,
    input logic [SIG_W-1:0]  exp_rm_sig,
    input logic              obs_valid,
    input logic [OP_W-1:0]   obs_op,
    input logic [OP_W-1:0]   obs_agu_op,
    input logic [XLEN-1:0]   obs_pc,
    input logic              obs_src1_vld,
    input logic [AREG_W-1:0] obs_src1,
    input logic              obs_src2_vld,
    input logic [AREG_W-1:0] obs_src2,
    input logic [XLEN-1:0]   obs_imm,
    input logic              obs_dst_vld,
    input logic [AREG_W-1:0] obs_dst,
    input logic              obs_sig_valid,
    input logic [SIG_W-1:0]  obs_pc_sig,
    input logic [SIG_W-1:0]  obs_rm_sig,
    input logic              br_valid,
    input logic [XLEN-1:0]   br_pred_npc,
    input logic [XLEN-1:0]   br_target,
    input logic              fix_valid,
    input logic [SIG_W-1:0]  fix_pc_sig
);
    logic same_rm;
    // Observed port describes exactly the decoded register/memory effects
    always_comb begin
        same_rm = dec_valid && obs_valid && (dec_op == obs_op) &&
                  (obs_agu_op == (is_mem(dec_op) ? OPC_ADD : OPC_NOP)) &&
                  (dec_src1_vld == obs_src1_vld) && (dec_src1 == obs_src1) &&
                  (dec_src2_vld == obs_src2_vld) && (dec_src2 == obs_src2) &&
                  (dec_imm == obs_imm) &&
                  (dec_dst_vld == obs_dst_vld) && (dec_dst == obs_dst);
    end

    if (REG_OUT) begin : g_chk
        // R9
        exp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dec_valid |=> exp_valid);
        // R9
        obs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !obs_valid |=> !obs_sig_valid);
        // R7
        rm_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
            same_rm |=> (exp_rm_sig == obs_rm_sig));
        // R3
        seq_pc_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_valid && obs_valid && !is_ctrl(dec_op) &&
             obs_pc == dec_pc + XLEN'(4)) |=> (exp_pc_sig == obs_pc_sig));
        // R8
        fix_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (br_valid && br_target != br_pred_npc) |=> fix_valid);
        // R8
        fix_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (br_valid && br_target == br_pred_npc) |=> !fix_valid);
        // R8
        fix_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (br_valid && obs_valid && obs_pc == br_target) |=>
            (fix_pc_sig == obs_pc_sig));
    end
endmodule

bind effect_sig_gen effect_sig_gen_chk #(
    .XLEN(XLEN), .AREG_W(AREG_W), .REG_OUT(REG_OUT)
) u_chk (.*);

// File: tb/effect_sig_gen_test.sv
// Self-checking bench: random micro-ops plus directed corners.
module effect_sig_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 0;
    logic [3:0]  dec_op = 0;
    logic [31:0] dec_pc = 0, dec_pred_npc = 0, dec_imm = 0;
    logic        dec_src1_vld = 0, dec_src2_vld = 0, dec_dst_vld = 0;
    logic [5:0]  dec_src1 = 0, dec_src2 = 0, dec_dst = 0;
    logic        exp_valid;
    logic [4:0]  exp_pc_sig, exp_rm_sig;
    logic        obs_valid = 0;
    logic [3:0]  obs_op = 0, obs_agu_op = 0;
    logic [31:0] obs_pc = 0, obs_imm = 0;
    logic        obs_src1_vld = 0, obs_src2_vld = 0, obs_dst_vld = 0;
    logic [5:0]  obs_src1 = 0, obs_src2 = 0, obs_dst = 0;
    logic        obs_sig_valid;
    logic [4:0]  obs_pc_sig, obs_rm_sig;
    logic        br_valid = 0;
    logic [31:0] br_pred_npc = 0, br_target = 0;
    logic        fix_valid;
    logic [4:0]  fix_pc_sig;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    effect_sig_gen uut (.*);

    function automatic logic [4:0] ref_crc(input logic [63:0] v, input int n);
        logic [4:0] c = 5'd0;
        for (int i = n - 1; i >= 0; i--) begin
            logic fb = c[4] ^ v[i];
            c = {c[3:0], 1'b0};
            if (fb) c = c ^ 5'b00101;
        end
        return c;
    endfunction

    function automatic logic [4:0] ref_rm(input logic [3:0] op, input logic [3:0] agu,
        input logic v1, input logic [5:0] r1, input logic v2, input logic [5:0] r2,
        input logic [31:0] imm, input logic vd, input logic [5:0] rd);
        logic [63:0] rec;
        rec = {3'b000, op, agu, v1, v1 ? r1 : 6'd0, v2, v2 ? r2 : 6'd0,
               imm, vd, vd ? rd : 6'd0};
        return ref_crc(rec, 61);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Copy the decoded fields onto the observed port, as a fault-free core would
    task automatic mirror_obs();
        obs_valid = 1; obs_op = dec_op;
        obs_agu_op = (dec_op == 4'd6 || dec_op == 4'd7) ? 4'd1 : 4'd0;
        obs_pc = dec_pc; obs_imm = dec_imm;
        obs_src1_vld = dec_src1_vld; obs_src1 = dec_src1;
        obs_src2_vld = dec_src2_vld; obs_src2 = dec_src2;
        obs_dst_vld = dec_dst_vld; obs_dst = dec_dst;
    endtask

    // Drive one cycle of stimulus, then compare all outputs one cycle later
    task automatic step_and_check();
        logic [31:0] npc;
        logic [3:0]  agu;
        logic [4:0]  e_pc, e_rm, o_pc, o_rm, f_pc;
        logic        f_v, ev, ov;
        npc  = (dec_op == 4'd8 || dec_op == 4'd9) ? dec_pred_npc : dec_pc + 32'd4;
        agu  = (dec_op == 4'd6 || dec_op == 4'd7) ? 4'd1 : 4'd0;
        e_pc = ref_crc({32'd0, npc}, 32);
        e_rm = ref_rm(dec_op, agu, dec_src1_vld, dec_src1, dec_src2_vld, dec_src2,
                      dec_imm, dec_dst_vld, dec_dst);
        o_pc = ref_crc({32'd0, obs_pc}, 32);
        o_rm = ref_rm(obs_op, obs_agu_op, obs_src1_vld, obs_src1, obs_src2_vld, obs_src2,
                      obs_imm, obs_dst_vld, obs_dst);
        f_pc = ref_crc({32'd0, br_target}, 32);
        f_v  = br_valid && (br_target != br_pred_npc);
        ev = dec_valid; ov = obs_valid;
        @(negedge clk);
        check("R9 exp_valid", 32'(exp_valid), 32'(ev));
        check("R3/R4 exp_pc_sig", 32'(exp_pc_sig), 32'(e_pc));
        check("R2/R5/R6 exp_rm_sig", 32'(exp_rm_sig), 32'(e_rm));
        check("R9 obs_sig_valid", 32'(obs_sig_valid), 32'(ov));
        check("R7 obs_pc_sig", 32'(obs_pc_sig), 32'(o_pc));
        check("R7 obs_rm_sig", 32'(obs_rm_sig), 32'(o_rm));
        check("R8 fix_valid", 32'(fix_valid), 32'(f_v));
        if (br_valid) check("R8 fix_pc_sig", 32'(fix_pc_sig), 32'(f_pc));
    endtask

    task automatic rand_dec();
        dec_valid = 1; dec_op = 4'($urandom_range(0, 9));
        dec_pc = $urandom & 32'hFFFF_FFFC; dec_pred_npc = $urandom;
        dec_imm = $urandom;
        dec_src1_vld = 1'($urandom); dec_src1 = 6'($urandom);
        dec_src2_vld = 1'($urandom); dec_src2 = 6'($urandom);
        dec_dst_vld  = 1'($urandom); dec_dst  = 6'($urandom);
    endtask

    initial begin
        logic [4:0] s_a;
        void'($urandom(32'd2024));
        // R1: outputs cleared under reset
        repeat (3) @(negedge clk);
        check("R1 exp_valid", 32'(exp_valid), 0);
        check("R1 exp sigs", 32'({exp_pc_sig, exp_rm_sig}), 0);
        check("R1 obs outputs", 32'({obs_sig_valid, obs_pc_sig, obs_rm_sig}), 0);
        check("R1 fix outputs", 32'({fix_valid, fix_pc_sig}), 0);
        rst_n = 1;

        // R3: sequential PC wraps past 2^32
        dec_valid = 1; dec_op = 4'd1; dec_pc = 32'hFFFF_FFFC; dec_imm = 32'h10;
        dec_src1_vld = 1; dec_src1 = 6'd3; dec_src2_vld = 1; dec_src2 = 6'd7;
        dec_dst_vld = 1; dec_dst = 6'd9;
        mirror_obs(); obs_pc = 32'h0;
        step_and_check();
        check("R3 wrap pc sig equals crc(0)", 32'(exp_pc_sig), 0);
        check("R7 obs matches exp rm", 32'(obs_rm_sig), 32'(exp_rm_sig));

        // R4: jump uses prediction; R5: load folds ADD
        dec_op = 4'd9; dec_pred_npc = 32'h0000_4000; mirror_obs();
        step_and_check();
        dec_op = 4'd6; dec_dst = 6'd1; mirror_obs();
        step_and_check();
        check("R5 load matches obs with ADD agu", 32'(obs_rm_sig), 32'(exp_rm_sig));
        obs_agu_op = 4'd0;
        step_and_check();

        // R6: masked source number is ignored
        dec_op = 4'd3; dec_src2_vld = 0; dec_src2 = 6'd5;
        br_valid = 0; obs_valid = 0;
        step_and_check();
        s_a = exp_rm_sig;
        dec_src2 = 6'd42;
        step_and_check();
        check("R6 masked src2 number has no effect", 32'(exp_rm_sig), 32'(s_a));

        // R8: agreeing and disagreeing resolution
        br_valid = 1; br_pred_npc = 32'h100; br_target = 32'h100;
        step_and_check();
        br_target = 32'h200;
        step_and_check();

        // Random mix, mostly mirrored so both sides agree
        for (int it = 0; it < 400; it++) begin
            rand_dec();
            if ($urandom_range(0, 3) != 0) begin
                mirror_obs();
                obs_pc = dec_pc + 32'd4;
            end else begin
                obs_valid = 1'($urandom); obs_op = 4'($urandom_range(0, 9));
                obs_agu_op = 4'($urandom); obs_pc = $urandom; obs_imm = $urandom;
                obs_src1_vld = 1'($urandom); obs_src1 = 6'($urandom);
            end
            if ($urandom_range(0, 4) == 0) dec_valid = 0;
            br_valid = 1'($urandom); br_pred_npc = $urandom;
            br_target = ($urandom_range(0, 1) == 0) ? br_pred_npc : $urandom;
            step_and_check();
        end

        // R1: synchronous reset clears outputs again
        rst_n = 0;
        @(negedge clk);
        check("R1 reset clears valids", 32'({exp_valid, obs_sig_valid, fix_valid}), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule